// File: doc/BRIEF.md
# Subtask Register-Bank and Base-Register Address Modifier

This block lets one task run as up to four subtasks that share code yet land on distinct
register banks and distinct memory base registers. A 2-bit subtask number is merged by
bitwise OR, not by addition, into fixed fields of two selectors: the low two bits of the
4-bit register-bank pointer, and bits [2:1] of the 5-bit memory base selector. The merged
bank pointer is joined with the 4-bit register index to form the register-file address. The
merged base selector picks one of 32 base registers, whose contents are added to the
virtual address to give the effective virtual address.

The merge applies only while the subtask enable is high and the current task number
equals the task that subtasking is armed for. In every other case both fields pass
through unchanged. The base register file has a synchronous write port and a combinational
read port. The whole path from the subtask bits to the effective address has no register in
it, so a merged selector is in place before the base addition within the same cycle, for any
virtual address.

Top module: `subtask_addr_mod`

## Requirements
- R1: `rf_addr` is `{effective bank pointer, rstk}`, with the bank pointer in bits [7:4] and `rstk` in bits [3:0].
- R2: While merging is active, the effective bank pointer is `rbase | subtask`, the subtask sitting in bank pointer bits [1:0]; with `rbase` = 0 and `rstk` = 0, subtask n gives `rf_addr` = 16·n.
- R3: While merging is active, `br_sel` is `mem_base | (subtask << 1)`, so subtasks 1, 2 and 3 OR in 2, 4 and 6.
- R4: Subtask 0 leaves both the bank pointer and `br_sel` equal to their inputs, even while merging is active.
- R5: Merging is active only when `sub_en` = 1 and `cur_task` equals `sel_task`; otherwise `rf_addr` = `{rbase, rstk}` and `br_sel` = `mem_base`.
- R6: `eff_va` equals the contents of base register `br_sel` plus `va`, modulo 2^16.
- R7: When `br_we` = 1 at a rising edge, base register `br_waddr` takes `br_wdata`, and the new value is seen on `eff_va` from that edge on; no other base register changes.
- R8: Reset clears all 32 base registers, so right after reset `eff_va` equals `va` for every selector.
- R9: A change of `subtask`, `sub_en` or `mem_base` shows on `eff_va` in the same cycle with no clock edge, for virtual addresses inside and outside 0..31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the base registers |
| cur_task | input | 4 | Number of the task now running |
| sel_task | input | 4 | Task number that subtask merging is armed for |
| sub_en | input | 1 | Subtask merging enable |
| subtask | input | 2 | Subtask number |
| rbase | input | 4 | Register-bank pointer from the instruction context |
| rstk | input | 4 | Register index within the bank |
| mem_base | input | 5 | Memory base register selector |
| va | input | 16 | Virtual address of the reference |
| br_we | input | 1 | Base register write enable |
| br_waddr | input | 5 | Base register write index |
| br_wdata | input | 16 | Base register write data |
| rf_addr | output | 8 | Effective register-file address |
| br_sel | output | 5 | Base register number used for the reference |
| eff_va | output | 16 | Effective virtual address |

## Verification
A wrong merge mask or a gating fault shows at once on `rf_addr` or `br_sel`, in the
same time step as the input change, since no register lies on those paths. A fault in
a base register's stored value shows on `eff_va` only when that entry is selected, so
every register is loaded with a distinct value (index times 512) and every selector is swept
against every subtask with merging on and off. A write landing in the wrong entry or on
the wrong edge shows on `eff_va` in the cycle after the write, and a neighbour entry is
read back to catch stray writes.

// File: rtl/subtask_pkg.sv
package subtask_pkg;
    localparam int TASK_W_D  = 4;
    localparam int SUB_W_D   = 2;
    localparam int BANK_W_D  = 4;
    localparam int IDX_W_D   = 4;
    localparam int SEL_W_D   = 5;
    localparam int DATA_W_D  = 16;
    localparam int BANK_SH_D = 0;   // subtask lands in bank pointer bits [1:0]
    localparam int SEL_SH_D  = 1;   // subtask lands in base selector bits [2:1]
endpackage

// File: rtl/subtask_gate.sv
module subtask_gate #(
    parameter int TASK_W = 4
) (
    input  logic              sub_en_i,
    input  logic [TASK_W-1:0] cur_task_i,
    input  logic [TASK_W-1:0] sel_task_i,
    output logic              active_o
);
    always_comb begin
        active_o = sub_en_i && (cur_task_i == sel_task_i);
    end
endmodule

// File: rtl/field_merge.sv
module field_merge #(
    parameter int FIELD_W = 4,
    parameter int SUB_W   = 2,
    parameter int SHIFT   = 0
) (
    input  logic               active_i,
    input  logic [SUB_W-1:0]   sub_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [FIELD_W-1:0] field_o
);
    logic [FIELD_W-1:0] mask;

    always_comb begin
        mask    = FIELD_W'(sub_i) << SHIFT;
        field_o = active_i ? (field_i | mask) : field_i;
    end
endmodule

// File: rtl/base_reg_file.sv
module base_reg_file #(
    parameter int SEL_W  = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SEL_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SEL_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int NREG = 1 << SEL_W;

    logic [DATA_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we_i && (waddr_i == SEL_W'(g))) begin
                regs[g] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = regs[raddr_i];
    end
endmodule

// File: rtl/subtask_addr_mod.sv
module subtask_addr_mod
    import subtask_pkg::*;
#(
    parameter int TASK_W  = TASK_W_D,
    parameter int SUB_W   = SUB_W_D,
    parameter int BANK_W  = BANK_W_D,
    parameter int IDX_W   = IDX_W_D,
    parameter int SEL_W   = SEL_W_D,
    parameter int DATA_W  = DATA_W_D,
    parameter int BANK_SH = BANK_SH_D,
    parameter int SEL_SH  = SEL_SH_D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [TASK_W-1:0]       cur_task,
    input  logic [TASK_W-1:0]       sel_task,
    input  logic                    sub_en,
    input  logic [SUB_W-1:0]        subtask,
    input  logic [BANK_W-1:0]       rbase,
    input  logic [IDX_W-1:0]        rstk,
    input  logic [SEL_W-1:0]        mem_base,
    input  logic [DATA_W-1:0]       va,
    input  logic                    br_we,
    input  logic [SEL_W-1:0]        br_waddr,
    input  logic [DATA_W-1:0]       br_wdata,
    output logic [BANK_W+IDX_W-1:0] rf_addr,
    output logic [SEL_W-1:0]        br_sel,
    output logic [DATA_W-1:0]       eff_va
);
    logic              active;
    logic [BANK_W-1:0] bank_eff;
    logic [SEL_W-1:0]  sel_eff;
    logic [DATA_W-1:0] base_val;

    subtask_gate #(.TASK_W(TASK_W)) u_gate (
        .sub_en_i   (sub_en),
        .cur_task_i (cur_task),
        .sel_task_i (sel_task),
        .active_o   (active)
    );

    field_merge #(.FIELD_W(BANK_W), .SUB_W(SUB_W), .SHIFT(BANK_SH)) u_bank_merge (
        .active_i (active),
        .sub_i    (subtask),
        .field_i  (rbase),
        .field_o  (bank_eff)
    );

    field_merge #(.FIELD_W(SEL_W), .SUB_W(SUB_W), .SHIFT(SEL_SH)) u_sel_merge (
        .active_i (active),
        .sub_i    (subtask),
        .field_i  (mem_base),
        .field_o  (sel_eff)
    );

    base_reg_file #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_brf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (br_we),
        .waddr_i (br_waddr),
        .wdata_i (br_wdata),
        .raddr_i (sel_eff),
        .rdata_o (base_val)
    );

    always_comb begin
        rf_addr = {bank_eff, rstk};
        br_sel  = sel_eff;
        eff_va  = base_val + va;
    end
endmodule

// File: rtl/subtask_addr_mod_chk.sv
module subtask_addr_mod_chk #(
    parameter int TASK_W = 4,
    parameter int SUB_W  = 2,
    parameter int BANK_W = 4,
    parameter int IDX_W  = 4,
    parameter int SEL_W  = 5,
    parameter int DATA_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [TASK_W-1:0]       cur_task,
    input logic [TASK_W-1:0]       sel_task,
    input logic                    sub_en,
    input logic [SUB_W-1:0]        subtask,
    input logic [BANK_W-1:0]       rbase,
    input logic [IDX_W-1:0]        rstk,
    input logic [SEL_W-1:0]        mem_base,
    input logic [DATA_W-1:0]       va,
    input logic                    br_we,
    input logic [SEL_W-1:0]        br_waddr,
    input logic [DATA_W-1:0]       br_wdata,
    input logic [BANK_W+IDX_W-1:0] rf_addr,
    input logic [SEL_W-1:0]        br_sel,
    input logic [DATA_W-1:0]       eff_va
);
    logic on;
    assign on = sub_en && (cur_task == sel_task);

    a_r1_index_low: assert property (@(posedge clk) disable iff (!rst_n)
        rf_addr[IDX_W-1:0] == rstk);

    a_r2_bank_or: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> rf_addr[BANK_W+IDX_W-1:IDX_W] == (rbase | BANK_W'(subtask)));

    a_r3_sel_or: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> br_sel == (mem_base | (SEL_W'(subtask) << 1)));

    a_r4_zero_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (subtask == '0) |-> (br_sel == mem_base) && (rf_addr == {rbase, rstk}));

    a_r5_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !on |-> (br_sel == mem_base) && (rf_addr == {rbase, rstk}));

    a_r7_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_we) && (br_sel == $past(br_waddr)))
            |-> eff_va == DATA_W'($past(br_wdata) + va));

    a_r8_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> eff_va == va);
endmodule

bind subtask_addr_mod subtask_addr_mod_chk #(
    .TASK_W(TASK_W), .SUB_W(SUB_W), .BANK_W(BANK_W),
    .IDX_W(IDX_W), .SEL_W(SEL_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_subtask_addr_mod.sv
`timescale 1ns/1ps
module tb_subtask_addr_mod;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cur_task = '0;
    logic [3:0]  sel_task = '0;
    logic        sub_en = 1'b0;
    logic [1:0]  subtask = '0;
    logic [3:0]  rbase = '0;
    logic [3:0]  rstk = '0;
    logic [4:0]  mem_base = '0;
    logic [15:0] va = '0;
    logic        br_we = 1'b0;
    logic [4:0]  br_waddr = '0;
    logic [15:0] br_wdata = '0;
    logic [7:0]  rf_addr;
    logic [4:0]  br_sel;
    logic [15:0] eff_va;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    subtask_addr_mod dut (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_br(input int idx, input int val);
        @(negedge clk);
        br_we = 1'b1; br_waddr = 5'(idx); br_wdata = 16'(val);
        @(negedge clk);
        br_we = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #600000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: all base registers zero after reset
        for (int m = 0; m < 32; m++) begin
            mem_base = 5'(m); va = 16'(m * 37 + 5); #1;
            chk("R8", "eff_va after reset", eff_va, m * 37 + 5);
        end
        // load base register i with i*512 (i * 1000 octal)
        for (int i = 0; i < 32; i++) write_br(i, i * 512);
        // R7: write seen next edge, neighbour untouched
        write_br(5, 16'hABCD);
        mem_base = 5'd5; va = 16'd3; sub_en = 1'b0; #1;
        chk("R7", "written entry", eff_va, (16'hABCD + 3) & 16'hFFFF);
        mem_base = 5'd4; #1;
        chk("R7", "neighbour entry", eff_va, 4 * 512 + 3);
        write_br(5, 5 * 512);
        mem_base = 5'd5; #1;
        chk("R7", "rewritten entry", eff_va, 5 * 512 + 3);
        // R2: rbase 0, rstk 0, subtask n -> word 16n
        cur_task = 4'd7; sel_task = 4'd7; sub_en = 1'b1; rbase = '0; rstk = '0;
        for (int s = 0; s < 4; s++) begin
            subtask = 2'(s); #1;
            chk("R2", "rf_addr bank word", rf_addr, s * 16);
        end
        // R9: subtask 3, base 0, va 0 -> 6000 octal; then va outside 0..31, no clock
        @(negedge clk);
        subtask = 2'd3; mem_base = '0; va = 16'd0; #1;
        chk("R9", "subtask 3 va 0", eff_va, 3072);
        va = 16'o1234; #1;
        chk("R9", "va outside low range", eff_va, 3072 + 'o1234);
        subtask = 2'd1; #1;
        chk("R9", "same-cycle subtask change", eff_va, 1024 + 'o1234);
        sub_en = 1'b0; #1;
        chk("R9", "same-cycle enable drop", eff_va, 'o1234);
        // exhaustive sweep
        for (int s = 0; s < 4; s++)
        for (int ctl = 0; ctl < 4; ctl++)
        for (int rb = 0; rb < 16; rb++)
        for (int mb = 0; mb < 32; mb++) begin
            int act_on, e_bank, e_sel, e_va, idx, vv;
            sub_en   = ctl[0];
            cur_task = 4'(rb ^ mb);
            sel_task = ctl[1] ? cur_task : cur_task ^ 4'd1;
            act_on   = ctl[0] & ctl[1];
            subtask  = 2'(s); rbase = 4'(rb); mem_base = 5'(mb);
            idx = (rb * 5 + mb) & 15;
            vv  = (s * 16411 + rb * 1021 + mb * 2053 + ctl * 40000) & 16'hFFFF;
            rstk = 4'(idx); va = 16'(vv);
            e_bank = act_on ? (rb | s) : rb;
            e_sel  = act_on ? (mb | (s << 1)) : mb;
            e_va   = (e_sel * 512 + vv) & 16'hFFFF;
            #1;
            if (!act_on) begin
                chk("R5", "br_sel passthrough", br_sel, mb);
                chk("R5", "rf_addr passthrough", rf_addr, rb * 16 + idx);
            end else if (s == 0) begin
                chk("R4", "br_sel subtask 0", br_sel, mb);
                chk("R4", "rf_addr subtask 0", rf_addr, rb * 16 + idx);
            end else begin
                chk("R3", "br_sel merged", br_sel, e_sel);
                chk("R2", "bank merged", rf_addr[7:4], e_bank);
            end
            chk("R1", "rstk field", rf_addr[3:0], idx);
            chk("R6", "eff_va sum", eff_va, e_va);
        end
        done = 1'b1;
        summary();
    end
endmodule